// File: doc/BRIEF.md
# USB Suspend Resume Power Controller

This block holds the 8-bit power control and status register of a USB device function and runs the suspend and resume sequencing behind it. Firmware writes the register to do four things: release the function from its post-reset inhibit, force a function reset, enable suspend detection and start remote-wakeup signaling. Firmware reads the register to see bus reset status and whether the function is suspended.

The line-state detectors sit outside the block. They supply three level indications: bus suspend, host resume and bus reset. The block answers with three outputs. The first drives resume signaling on the bus. The second inhibits traffic. The third is a one-cycle function-reset pulse. A one-cycle interrupt pulse marks the end of a remote wakeup.

Suspend can be left in two ways. Firmware can end its own resume drive by writing the resume bit back to 0. Or the host resumes the bus: that event is latched as pending, and firmware then reads the common interrupt register.

Top module: `usb_pwr_ctrl`

## Requirements
- R1: After reset the register reads 0x10, `traffic_inhibit` is 1, and `resume_drive`, `irq_pulse` and `func_rst` are 0.
- R2: Bits 6 and 5 always read 0. Bit 7 and bit 0 (suspend-detect enable) store the value of every write that does not force a reset.
- R3: Bit 4 (inhibit) is cleared by a write with bit 4 = 0. A write with bit 4 = 1 leaves it unchanged. `traffic_inhibit` equals bit 4. While bit 4 is 1, bus suspend and host resume indications are ignored.
- R4: Bit 3 reads `bus_reset_det` in the same cycle. A write with bit 3 = 1 raises `func_rst` for exactly one cycle after that edge and returns all state to the R1 values, overriding every other event in that cycle.
- R5: Bit 1 (suspend mode) is set one cycle after `bus_suspend_det` is seen while bit 0 is 1 and bit 4 is 0. Writes never change bit 1 directly.
- R6: A write with bit 2 = 1 while bit 1 is 1 sets bit 2 and `resume_drive` on the next cycle. The same write while bit 1 is 0 leaves bit 2 at 0.
- R7: A write with bit 2 = 0 while bit 2 is 1 clears bit 2, `resume_drive` and bit 1 on the next cycle, and raises `irq_pulse` for exactly that one cycle.
- R8: `bus_resume_det` while suspended and not inhibited latches a pending host resume. A `cmint_rd` while a host resume is pending clears bit 1 on the next cycle. A `cmint_rd` with nothing pending has no effect.
- R9: When a suspend exit and a suspend entry condition occur in the same cycle, the exit wins and bit 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Power register write strobe |
| reg_wdata | input | 8 | Power register write data |
| bus_suspend_det | input | 1 | Bus suspend condition detected |
| bus_resume_det | input | 1 | Host resume signaling detected |
| bus_reset_det | input | 1 | Bus reset signaling present |
| cmint_rd | input | 1 | Read strobe of the common interrupt register |
| reg_rdata | output | 8 | Power register read value |
| resume_drive | output | 1 | Drive resume signaling on the bus |
| traffic_inhibit | output | 1 | All bus traffic ignored while high |
| func_rst | output | 1 | One-cycle forced function reset |
| irq_pulse | output | 1 | One-cycle interrupt at end of remote wakeup |

## Verification
The hardest state to reach is one where a suspend exit collides with a suspend entry. For that, the enable must be set, inhibit must already be cleared, suspend must have been entered, and then a host resume must be pending or a remote wakeup must be in progress, all at once. Directed sequences climb that ladder step by step. They then end a wakeup while bus suspend is still asserted, and read the common interrupt register both with and without a pending resume. After that, biased random traffic runs with forced resets kept rare, so that the function spends long stretches uninhibited and suspended. Every cycle is compared against a bench model built from the requirements.

// File: rtl/usbpwr_pkg.sv
package usbpwr_pkg;
  localparam int unsigned PWR_W     = 8;
  localparam int unsigned B_ISO     = 7;
  localparam int unsigned B_INHIBIT = 4;
  localparam int unsigned B_BUSRST  = 3;
  localparam int unsigned B_RESUME  = 2;
  localparam int unsigned B_SUSPEND = 1;
  localparam int unsigned B_SUSEN   = 0;
  localparam logic [PWR_W-1:0] PWR_RESET_VAL = PWR_W'(1) << B_INHIBIT;
endpackage

// File: rtl/usbpwr_inhibit.sv
module usbpwr_inhibit (
  input  logic clk,
  input  logic rst_n,
  input  logic force_rst,
  input  logic inh_clr,
  output logic inh_q,
  output logic func_rst_q
);
  logic inh_d;
  logic frst_d;

  always_comb begin
    inh_d  = inh_q;
    frst_d = force_rst;
    if (force_rst)    inh_d = 1'b1;
    else if (inh_clr) inh_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q      <= 1'b1;
      func_rst_q <= 1'b0;
    end else begin
      inh_q      <= inh_d;
      func_rst_q <= frst_d;
    end
  end

  // R3
  inh_only_by_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inh_q) |-> $past(force_rst));
  // R4
  func_rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func_rst_q |-> inh_q);
endmodule

// File: rtl/usbpwr_susp.sv
module usbpwr_susp (
  input  logic clk,
  input  logic rst_n,
  input  logic force_rst,
  input  logic wr_en,
  input  logic wd_resume,
  input  logic wd_susen,
  input  logic inhibited,
  input  logic bus_suspend,
  input  logic bus_resume,
  input  logic cmint_rd,
  output logic susp_q,
  output logic resume_q,
  output logic pend_q,
  output logic susen_q,
  output logic irq_q
);
  logic susp_d, resume_d, pend_d, susen_d, irq_d;
  logic wake_end, wake_start, host_exit, exit_any;

  always_comb begin
    wake_end   = wr_en && !wd_resume && resume_q;
    wake_start = wr_en &&  wd_resume && susp_q && !resume_q;
    host_exit  = cmint_rd && pend_q;
    exit_any   = wake_end || host_exit;

    susp_d   = susp_q;
    resume_d = resume_q;
    pend_d   = pend_q;
    susen_d  = wr_en ? wd_susen : susen_q;
    irq_d    = 1'b0;

    if (force_rst) begin
      susp_d   = 1'b0;
      resume_d = 1'b0;
      pend_d   = 1'b0;
      susen_d  = 1'b0;
    end else begin
      if (wake_end)        resume_d = 1'b0;
      else if (wake_start) resume_d = 1'b1;

      if (exit_any)
        susp_d = 1'b0;
      else if (bus_suspend && susen_q && !inhibited)
        susp_d = 1'b1;

      if (exit_any)
        pend_d = 1'b0;
      else if (bus_resume && susp_q && !inhibited)
        pend_d = 1'b1;

      irq_d = wake_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q   <= 1'b0;
      resume_q <= 1'b0;
      pend_q   <= 1'b0;
      susen_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      susp_q   <= susp_d;
      resume_q <= resume_d;
      pend_q   <= pend_d;
      susen_q  <= susen_d;
      irq_q    <= irq_d;
    end
  end

  // R5
  susp_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> $past(susen_q && bus_suspend && !inhibited));
  // R6
  resume_only_suspended_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_q) |-> $past(susp_q));
  // R7
  wake_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(resume_q) && !$past(force_rst)) |-> (irq_q && !susp_q));
  // R7
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R8
  pend_implies_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> susp_q);
endmodule

// File: rtl/usb_pwr_ctrl.sv
module usb_pwr_ctrl
  import usbpwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [PWR_W-1:0] reg_wdata,
  input  logic             bus_suspend_det,
  input  logic             bus_resume_det,
  input  logic             bus_reset_det,
  input  logic             cmint_rd,
  output logic [PWR_W-1:0] reg_rdata,
  output logic             resume_drive,
  output logic             traffic_inhibit,
  output logic             func_rst,
  output logic             irq_pulse
);
  logic force_rst, inh_clr;
  logic inh_q, susp_q, resume_q, pend_q, susen_q;
  logic iso_q, iso_d;

  assign force_rst = reg_wr_en && reg_wdata[B_BUSRST];
  assign inh_clr   = reg_wr_en && !reg_wdata[B_INHIBIT];

  usbpwr_inhibit u_inh (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_rst  (force_rst),
    .inh_clr    (inh_clr),
    .inh_q      (inh_q),
    .func_rst_q (func_rst)
  );

  usbpwr_susp u_susp (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_rst   (force_rst),
    .wr_en       (reg_wr_en),
    .wd_resume   (reg_wdata[B_RESUME]),
    .wd_susen    (reg_wdata[B_SUSEN]),
    .inhibited   (inh_q),
    .bus_suspend (bus_suspend_det),
    .bus_resume  (bus_resume_det),
    .cmint_rd    (cmint_rd),
    .susp_q      (susp_q),
    .resume_q    (resume_q),
    .pend_q      (pend_q),
    .susen_q     (susen_q),
    .irq_q       (irq_pulse)
  );

  always_comb begin
    iso_d = iso_q;
    if (force_rst)      iso_d = 1'b0;
    else if (reg_wr_en) iso_d = reg_wdata[B_ISO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iso_q <= 1'b0;
    else        iso_q <= iso_d;
  end

  always_comb begin
    reg_rdata            = '0;
    reg_rdata[B_ISO]     = iso_q;
    reg_rdata[B_INHIBIT] = inh_q;
    reg_rdata[B_BUSRST]  = bus_reset_det;
    reg_rdata[B_RESUME]  = resume_q;
    reg_rdata[B_SUSPEND] = susp_q;
    reg_rdata[B_SUSEN]   = susen_q;
  end

  assign resume_drive    = resume_q;
  assign traffic_inhibit = inh_q;

  // R4
  force_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func_rst |-> (!iso_q && !susen_q && !resume_drive && !irq_pulse));
  // R2
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:5] == 2'b00);
endmodule

// File: tb/usb_pwr_ctrl_bench.sv
module usb_pwr_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic wr;
  logic [7:0] wd;
  logic sd, rd, rs, cm;
  logic [7:0] rdata;
  logic rdrv, tinh, frst, irq;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  logic m_iso, m_inh, m_res, m_sus, m_pend, m_sen, m_irq, m_frst;

  always #4 clk = ~clk;

  usb_pwr_ctrl u_usb_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_wdata(wd),
    .bus_suspend_det(sd), .bus_resume_det(rd), .bus_reset_det(rs),
    .cmint_rd(cm), .reg_rdata(rdata), .resume_drive(rdrv),
    .traffic_inhibit(tinh), .func_rst(frst), .irq_pulse(irq)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_iso = 0; m_inh = 1; m_res = 0; m_sus = 0; m_pend = 0; m_sen = 0;
    m_irq = 0; m_frst = 0;
  endfunction

  function automatic void model_step();
    logic end_w, start_w, host_x, ex;
    if (wr && wd[3]) begin
      model_reset();
      m_frst = 1;
      return;
    end
    m_frst  = 0;
    end_w   = wr && !wd[2] && m_res;
    start_w = wr && wd[2] && m_sus && !m_res;
    host_x  = cm && m_pend;
    ex      = end_w || host_x;
    if (ex) m_pend = 0; else if (rd && m_sus && !m_inh) m_pend = 1;
    if (ex) m_sus = 0;  else if (sd && m_sen && !m_inh) m_sus = 1;
    if (end_w) m_res = 0; else if (start_w) m_res = 1;
    m_irq = end_w;
    if (wr) begin
      m_iso = wd[7];
      m_sen = wd[0];
      if (!wd[4]) m_inh = 0;
    end
  endfunction

  task automatic compare();
    chk("R2", "bit7",    {7'b0, rdata[7]}, {7'b0, m_iso});
    chk("R2", "bits6_5", {6'b0, rdata[6:5]}, 8'h00);
    chk("R3", "inhibit", {6'b0, rdata[4], tinh}, {6'b0, m_inh, m_inh});
    chk("R4", "busrst",  {7'b0, rdata[3]}, {7'b0, rs});
    chk("R6", "resume",  {6'b0, rdata[2], rdrv}, {6'b0, m_res, m_res});
    chk("R5", "suspend", {7'b0, rdata[1]}, {7'b0, m_sus});
    chk("R2", "susen",   {7'b0, rdata[0]}, {7'b0, m_sen});
    chk("R7", "irq",     {7'b0, irq}, {7'b0, m_irq});
    chk("R4", "func_rst",{7'b0, frst}, {7'b0, m_frst});
  endtask

  task automatic apply(logic w, logic [7:0] d, logic s, logic r, logic b, logic c);
    wr = w; wd = d; sd = s; rd = r; rs = b; cm = c;
    model_step();
    @(posedge clk);
    #2;
    compare();
  endtask

  task automatic idle();
    apply(0, 8'h00, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd20250611);
    wr = 0; wd = 0; sd = 0; rd = 0; rs = 0; cm = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "reset rdata", rdata, 8'h10);
    chk("R1", "reset outs", {4'b0, rdrv, tinh, frst, irq}, 8'h04);
    idle();
    // R5 suspend ignored while disabled and inhibited
    apply(0, 8'h00, 1, 0, 0, 0);
    // R2 unused bits, bit7 stored, inhibit kept by write of 1 (R3)
    apply(1, 8'hF1, 1, 0, 0, 0);
    chk("R3", "inhibit kept", {7'b0, tinh}, 8'h01);
    // R3 suspend ignored while inhibited
    apply(0, 8'h00, 1, 1, 0, 0);
    // R3 clear inhibit, keep enable
    apply(1, 8'h01, 0, 0, 0, 0);
    apply(1, 8'h11, 0, 0, 0, 0);
    chk("R3", "write 1 no set", {7'b0, tinh}, 8'h00);
    // R6 resume ignored when not suspended
    apply(1, 8'h05, 0, 0, 0, 0);
    chk("R6", "resume ignored", {7'b0, rdrv}, 8'h00);
    // R8 cmint with nothing pending
    apply(0, 8'h00, 0, 0, 0, 1);
    // R5 enter suspend
    apply(0, 8'h00, 1, 0, 0, 0);
    chk("R5", "suspended", {7'b0, rdata[1]}, 8'h01);
    // R8 host resume, then cmint read
    apply(0, 8'h00, 0, 1, 0, 0);
    apply(0, 8'h00, 0, 0, 0, 0);
    chk("R8", "pending keeps suspend", {7'b0, rdata[1]}, 8'h01);
    apply(0, 8'h00, 1, 0, 0, 1);
    chk("R9", "host exit wins", {7'b0, rdata[1]}, 8'h00);
    // R6/R7 remote wakeup
    apply(0, 8'h00, 1, 0, 0, 0);
    apply(1, 8'h05, 0, 0, 0, 0);
    chk("R6", "resume drive", {7'b0, rdrv}, 8'h01);
    apply(1, 8'h05, 0, 0, 0, 0);
    apply(1, 8'h01, 1, 0, 0, 0);
    chk("R7", "irq on end", {6'b0, irq, rdata[1]}, 8'h02);
    idle();
    // R4 bus reset status and forced reset
    apply(0, 8'h00, 0, 0, 1, 0);
    apply(1, 8'h8D, 1, 1, 0, 1);
    chk("R4", "forced reset value", rdata, 8'h10);
    idle();
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (($urandom % 40) != 0) d[3] = 1'b0;
      if (($urandom % 4) != 0) d[4] = 1'b0;
      apply(($urandom % 5) == 0, d, ($urandom % 3) == 0, ($urandom % 4) == 0,
            ($urandom % 6) == 0, ($urandom % 5) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule